// File: doc/BRIEF.md
# Protected-Mode Interrupt Gate Dispatcher

This block turns pending events into a dispatch through a gate table in memory. Four sources can request service: internally detected exceptions, a non-maskable request, software interrupt instructions and a maskable external request. An interrupt-enable flag, set and cleared by commands, holds back only the maskable request. The winning source's identifier selects an 8-byte gate descriptor. The gate table's base and limit sit in a table register that software loads and reads back, and loading a new value switches tables.

The descriptor is fetched through a one-shot 64-bit read port and then decoded. A task gate yields a task-switch request carrying the gate's selector. An interrupt gate or a trap gate yields an in-task procedure entry after a privilege test against the target code segment, which is looked up through a small query port. Before the entry is granted the block emits three stack-push words. An illegal, absent or out-of-limit gate, or one that fails the privilege test, yields a protection fault. The task-switch engine, segment loading and instruction decoding belong to neighbouring blocks.

Descriptor layout: bits 15:0 entry offset, bits 31:16 selector, bits 43:40 type, bit 47 present. The other bits are ignored.

Top module: `gateDispatch`

## Requirements
- R1: After reset `ieFlag` is 0. `setIe` sets it and `clrIe` clears it from the next cycle, and `clrIe` wins when both are high.
- R2: `extReq` is accepted only while `ieFlag` is 1. `excReq`, `nmiReq` and `swReq` are accepted whatever the flag's value.
- R3: Among requests that are high in the same idle cycle, the priority is exception, then non-maskable, then software, then external. `srcAck` is one-hot with bit 0 for exception, bit 1 for non-maskable, bit 2 for software and bit 3 for external. The non-maskable identifier is 2.
- R4: The descriptor read address is table base plus identifier times 8. `memRd` is raised only during a dispatch.
- R5: If identifier*8+7 exceeds the table limit, a fault with code 1 results and no read is issued.
- R6: `tblLoad` in an idle cycle loads base and limit, which read back on `tblBase` and `tblLimit` and are used by later dispatches. `tblLoad` while `busy` is ignored.
- R7: Only gate types 5, 6 and 7 are legal. Any other type faults with code 1, and this test is made before the present test.
- R8: A legal gate whose present bit is 0 faults with code 2, and no segment query is made.
- R9: A present type-5 gate raises `taskSwitch` with `taskSel` equal to the gate selector, and no push words are produced.
- R10: For types 6 and 7, entry is allowed only if the target segment is conforming or its privilege level is at most `cpl`. Otherwise the result is a fault with code 1.
- R11: On entry, three push words are produced in this order: flag word at sp-2, `csIn` at sp-4, `ipIn` at sp-6. `stackPtr` ends at sp-6, and `procEntry` carries the gate selector and offset.
- R12: `entryFlags` is the captured flag word with bit 8 (single-step) cleared. A type-6 gate also clears bit 9 there and clears `ieFlag`, while a type-7 gate leaves `ieFlag` unchanged.
- R13: When `setIe` coincides with the entry cycle of a type-6 gate, `ieFlag` ends cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extReq | input | 1 | Maskable external request |
| extVec | input | 8 | Identifier for the external request |
| nmiReq | input | 1 | Non-maskable request |
| swReq | input | 1 | Software interrupt request |
| swVec | input | 8 | Software interrupt identifier |
| excReq | input | 1 | Exception request |
| excVec | input | 8 | Exception identifier |
| srcAck | output | 4 | One-hot acceptance of a source |
| setIe | input | 1 | Set interrupt-enable command |
| clrIe | input | 1 | Clear interrupt-enable command |
| ieFlag | output | 1 | Interrupt-enable flag |
| cpl | input | 2 | Current privilege level |
| flagsIn | input | 16 | Flag word captured at acceptance |
| csIn | input | 16 | Return code selector |
| ipIn | input | 16 | Return offset |
| spIn | input | 16 | Stack pointer at acceptance |
| tblLoad | input | 1 | Table register load strobe |
| tblBaseIn | input | 24 | Base to load |
| tblLimitIn | input | 16 | Limit to load |
| tblBase | output | 24 | Table base read-back |
| tblLimit | output | 16 | Table limit read-back |
| memRd | output | 1 | Descriptor read request |
| memAddr | output | 24 | Descriptor byte address |
| memAck | input | 1 | Read data valid |
| memRdata | input | 64 | Descriptor data |
| segQuery | output | 1 | Target segment query |
| segSel | output | 16 | Selector being queried |
| segAck | input | 1 | Query answer valid |
| segDpl | input | 2 | Target segment privilege level |
| segConf | input | 1 | Target segment is conforming |
| busy | output | 1 | Dispatch in progress |
| dispVec | output | 8 | Identifier being dispatched |
| taskSwitch | output | 1 | Task-switch request pulse |
| taskSel | output | 16 | Task state segment selector |
| procEntry | output | 1 | Procedure entry pulse |
| entrySel | output | 16 | Entry code selector |
| entryOff | output | 16 | Entry offset |
| entryFlags | output | 16 | Flag word in force after entry |
| pushValid | output | 1 | Push word valid |
| pushAddr | output | 16 | Push word stack address |
| pushData | output | 16 | Push word |
| stackPtr | output | 16 | Working stack pointer |
| fault | output | 1 | Protection fault pulse |
| faultCode | output | 2 | 1 general protection, 2 not present |

## Verification
Two functions can land on `ieFlag` in the same cycle: the automatic clear made by an interrupt-gate entry, and a software `setIe` command. The bench raises `setIe` exactly in the cycle where it sees `procEntry` for a type-6 gate. It then judges at the port that the flag reads 0 on the following cycle. A separate run without the command, and a trap-gate run with the flag set, show that the clear comes from the gate type alone.

// File: rtl/gateDispPkg.sv
package gateDispPkg;
  localparam int WORD_W = 16;
  localparam int TF_BIT = 8;
  localparam int IF_BIT = 9;
  localparam logic [3:0] GT_TASK = 4'd5;
  localparam logic [3:0] GT_INTR = 4'd6;
  localparam logic [3:0] GT_TRAP = 4'd7;
  localparam logic [1:0] FLT_GP = 2'd1;
  localparam logic [1:0] FLT_NP = 2'd2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CHECK, ST_FETCH, ST_DECODE, ST_SEGQ,
    ST_PUSH0, ST_PUSH1, ST_PUSH2, ST_ENTRY, ST_TASK, ST_FAULT
  } dispStateT;

  typedef struct packed {
    logic       capture;
    logic       tblWr;
    logic       descLoad;
    logic       spDec;
    logic [1:0] pushSel;
  } dpStrobeT;
endpackage

// File: rtl/gateDispDatapath.sv
module gateDispDatapath
  import gateDispPkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int LIMIT_W = 16,
  parameter int VEC_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobeT            stb,
  input  logic [VEC_W-1:0]    capVec,
  input  logic [ADDR_W-1:0]   tblBaseIn,
  input  logic [LIMIT_W-1:0]  tblLimitIn,
  input  logic [WORD_W-1:0]   flagsIn,
  input  logic [WORD_W-1:0]   csIn,
  input  logic [WORD_W-1:0]   ipIn,
  input  logic [WORD_W-1:0]   spIn,
  input  logic [4*WORD_W-1:0] memRdata,
  output logic [ADDR_W-1:0]   tblBase,
  output logic [LIMIT_W-1:0]  tblLimit,
  output logic [ADDR_W-1:0]   memAddr,
  output logic                limitFail,
  output logic [VEC_W-1:0]    vecOut,
  output logic [3:0]          gateType,
  output logic                gatePresent,
  output logic [WORD_W-1:0]   gateSel,
  output logic [WORD_W-1:0]   gateOff,
  output logic [WORD_W-1:0]   pushAddr,
  output logic [WORD_W-1:0]   pushData,
  output logic [WORD_W-1:0]   stackPtr,
  output logic [WORD_W-1:0]   entryFlags
);
  localparam int OFS_W = VEC_W + 3;

  logic [ADDR_W-1:0]  baseQ;
  logic [LIMIT_W-1:0] limitQ;
  logic [VEC_W-1:0]   vecQ;
  logic [WORD_W-1:0]  flagsQ, csQ, ipQ, spQ, selQ, offQ;
  logic [3:0]         typeQ;
  logic               presQ;
  logic [OFS_W-1:0]   lastByte;
  logic [WORD_W-1:0]  clrMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ  <= '0;
      limitQ <= '0;
      vecQ   <= '0;
      flagsQ <= '0;
      csQ    <= '0;
      ipQ    <= '0;
      spQ    <= '0;
      selQ   <= '0;
      offQ   <= '0;
      typeQ  <= '0;
      presQ  <= 1'b0;
    end else begin
      if (stb.tblWr) begin
        baseQ  <= tblBaseIn;
        limitQ <= tblLimitIn;
      end
      if (stb.capture) begin
        vecQ   <= capVec;
        flagsQ <= flagsIn;
        csQ    <= csIn;
        ipQ    <= ipIn;
        spQ    <= spIn;
      end else if (stb.spDec) begin
        spQ <= spQ - WORD_W'(2);
      end
      if (stb.descLoad) begin
        offQ  <= memRdata[15:0];
        selQ  <= memRdata[31:16];
        typeQ <= memRdata[43:40];
        presQ <= memRdata[47];
      end
    end
  end

  assign lastByte  = {vecQ, 3'b111};
  assign limitFail = LIMIT_W'(lastByte) > limitQ;
  assign memAddr   = baseQ + ADDR_W'({vecQ, 3'b000});

  always_comb begin
    case (stb.pushSel)
      2'd0:    pushData = flagsQ;
      2'd1:    pushData = csQ;
      default: pushData = ipQ;
    endcase
    clrMask = WORD_W'(1) << TF_BIT;
    if (typeQ == GT_INTR) clrMask = clrMask | (WORD_W'(1) << IF_BIT);
  end

  assign entryFlags  = flagsQ & ~clrMask;
  assign pushAddr    = spQ - WORD_W'(2);
  assign stackPtr    = spQ;
  assign tblBase     = baseQ;
  assign tblLimit    = limitQ;
  assign vecOut      = vecQ;
  assign gateType    = typeQ;
  assign gatePresent = presQ;
  assign gateSel     = selQ;
  assign gateOff     = offQ;

  // R11
  sp_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.spDec && !stb.capture) |=> (spQ == $past(pushAddr)));
endmodule

// File: rtl/gateDispControl.sv
module gateDispControl
  import gateDispPkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int NMI_VEC = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             extReq,
  input  logic [VEC_W-1:0] extVec,
  input  logic             nmiReq,
  input  logic             swReq,
  input  logic [VEC_W-1:0] swVec,
  input  logic             excReq,
  input  logic [VEC_W-1:0] excVec,
  input  logic             setIe,
  input  logic             clrIe,
  input  logic             tblLoad,
  input  logic             memAck,
  input  logic             segAck,
  input  logic [1:0]       segDpl,
  input  logic             segConf,
  input  logic [1:0]       cpl,
  input  logic             limitFail,
  input  logic [3:0]       gateType,
  input  logic             gatePresent,
  output dpStrobeT         stb,
  output logic [VEC_W-1:0] capVec,
  output logic [3:0]       srcAck,
  output logic             ieFlag,
  output logic             memRd,
  output logic             segQuery,
  output logic             busy,
  output logic             taskSwitch,
  output logic             procEntry,
  output logic             pushValid,
  output logic             fault,
  output logic [1:0]       faultCode
);
  dispStateT state, nxt;
  logic       ieQ;
  logic [1:0] faultQ;
  logic       fltSet;
  logic [1:0] fltVal;
  logic       legalType;

  assign legalType = (gateType == GT_TASK) || (gateType == GT_INTR) || (gateType == GT_TRAP);

  always_comb begin
    nxt       = state;
    stb       = '0;
    capVec    = '0;
    srcAck    = '0;
    memRd     = 1'b0;
    segQuery  = 1'b0;
    pushValid = 1'b0;
    fltSet    = 1'b0;
    fltVal    = FLT_GP;
    case (state)
      ST_IDLE: begin
        stb.tblWr = tblLoad;
        if (excReq) begin
          srcAck[0] = 1'b1;
          capVec    = excVec;
        end else if (nmiReq) begin
          srcAck[1] = 1'b1;
          capVec    = VEC_W'(NMI_VEC);
        end else if (swReq) begin
          srcAck[2] = 1'b1;
          capVec    = swVec;
        end else if (extReq && ieQ) begin
          srcAck[3] = 1'b1;
          capVec    = extVec;
        end
        if (|srcAck) begin
          stb.capture = 1'b1;
          nxt         = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (limitFail) begin
          fltSet = 1'b1;
          nxt    = ST_FAULT;
        end else begin
          nxt = ST_FETCH;
        end
      end
      ST_FETCH: begin
        memRd = 1'b1;
        if (memAck) begin
          stb.descLoad = 1'b1;
          nxt          = ST_DECODE;
        end
      end
      ST_DECODE: begin
        if (!legalType) begin
          fltSet = 1'b1;
          nxt    = ST_FAULT;
        end else if (!gatePresent) begin
          fltSet = 1'b1;
          fltVal = FLT_NP;
          nxt    = ST_FAULT;
        end else if (gateType == GT_TASK) begin
          nxt = ST_TASK;
        end else begin
          nxt = ST_SEGQ;
        end
      end
      ST_SEGQ: begin
        segQuery = 1'b1;
        if (segAck) begin
          if (segConf || (segDpl <= cpl)) begin
            nxt = ST_PUSH0;
          end else begin
            fltSet = 1'b1;
            nxt    = ST_FAULT;
          end
        end
      end
      ST_PUSH0: begin
        pushValid   = 1'b1;
        stb.pushSel = 2'd0;
        stb.spDec   = 1'b1;
        nxt         = ST_PUSH1;
      end
      ST_PUSH1: begin
        pushValid   = 1'b1;
        stb.pushSel = 2'd1;
        stb.spDec   = 1'b1;
        nxt         = ST_PUSH2;
      end
      ST_PUSH2: begin
        pushValid   = 1'b1;
        stb.pushSel = 2'd2;
        stb.spDec   = 1'b1;
        nxt         = ST_ENTRY;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      ieQ    <= 1'b0;
      faultQ <= '0;
    end else begin
      state <= nxt;
      if (fltSet) faultQ <= fltVal;
      if (state == ST_ENTRY && gateType == GT_INTR) ieQ <= 1'b0;
      else if (clrIe)                                ieQ <= 1'b0;
      else if (setIe)                                ieQ <= 1'b1;
    end
  end

  assign ieFlag     = ieQ;
  assign busy       = (state != ST_IDLE);
  assign taskSwitch = (state == ST_TASK);
  assign procEntry  = (state == ST_ENTRY);
  assign fault      = (state == ST_FAULT);
  assign faultCode  = faultQ;

  // R3
  src_onehot_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0(srcAck));
  // R2
  ext_masked_chk: assert property (@(posedge clk) disable iff (!rstN) srcAck[3] |-> ieQ);
  // R5
  limit_no_read_chk: assert property (@(posedge clk) disable iff (!rstN) memRd |-> !limitFail);
  // R8
  np_before_priv_chk: assert property (@(posedge clk) disable iff (!rstN) segQuery |-> gatePresent);
  // R1
  clr_ie_chk: assert property (@(posedge clk) disable iff (!rstN) clrIe |=> !ieFlag);
  // R13
  entry_beats_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (procEntry && gateType == GT_INTR) |=> !ieFlag);
endmodule

// File: rtl/gateDispatch.sv
module gateDispatch
  import gateDispPkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int LIMIT_W = 16,
  parameter int VEC_W   = 8,
  parameter int NMI_VEC = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               extReq,
  input  logic [VEC_W-1:0]   extVec,
  input  logic               nmiReq,
  input  logic               swReq,
  input  logic [VEC_W-1:0]   swVec,
  input  logic               excReq,
  input  logic [VEC_W-1:0]   excVec,
  output logic [3:0]         srcAck,
  input  logic               setIe,
  input  logic               clrIe,
  output logic               ieFlag,
  input  logic [1:0]         cpl,
  input  logic [15:0]        flagsIn,
  input  logic [15:0]        csIn,
  input  logic [15:0]        ipIn,
  input  logic [15:0]        spIn,
  input  logic               tblLoad,
  input  logic [ADDR_W-1:0]  tblBaseIn,
  input  logic [LIMIT_W-1:0] tblLimitIn,
  output logic [ADDR_W-1:0]  tblBase,
  output logic [LIMIT_W-1:0] tblLimit,
  output logic               memRd,
  output logic [ADDR_W-1:0]  memAddr,
  input  logic               memAck,
  input  logic [63:0]        memRdata,
  output logic               segQuery,
  output logic [15:0]        segSel,
  input  logic               segAck,
  input  logic [1:0]         segDpl,
  input  logic               segConf,
  output logic               busy,
  output logic [VEC_W-1:0]   dispVec,
  output logic               taskSwitch,
  output logic [15:0]        taskSel,
  output logic               procEntry,
  output logic [15:0]        entrySel,
  output logic [15:0]        entryOff,
  output logic [15:0]        entryFlags,
  output logic               pushValid,
  output logic [15:0]        pushAddr,
  output logic [15:0]        pushData,
  output logic [15:0]        stackPtr,
  output logic               fault,
  output logic [1:0]         faultCode
);
  dpStrobeT          stb;
  logic [VEC_W-1:0]  capVec;
  logic              limitFail;
  logic [3:0]        gateType;
  logic              gatePresent;
  logic [15:0]       gateSel, gateOff;

  gateDispControl #(.VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .extReq(extReq), .extVec(extVec), .nmiReq(nmiReq),
    .swReq(swReq), .swVec(swVec), .excReq(excReq), .excVec(excVec),
    .setIe(setIe), .clrIe(clrIe), .tblLoad(tblLoad),
    .memAck(memAck), .segAck(segAck), .segDpl(segDpl), .segConf(segConf),
    .cpl(cpl), .limitFail(limitFail), .gateType(gateType), .gatePresent(gatePresent),
    .stb(stb), .capVec(capVec), .srcAck(srcAck), .ieFlag(ieFlag),
    .memRd(memRd), .segQuery(segQuery), .busy(busy),
    .taskSwitch(taskSwitch), .procEntry(procEntry), .pushValid(pushValid),
    .fault(fault), .faultCode(faultCode)
  );

  gateDispDatapath #(.ADDR_W(ADDR_W), .LIMIT_W(LIMIT_W), .VEC_W(VEC_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .capVec(capVec),
    .tblBaseIn(tblBaseIn), .tblLimitIn(tblLimitIn),
    .flagsIn(flagsIn), .csIn(csIn), .ipIn(ipIn), .spIn(spIn), .memRdata(memRdata),
    .tblBase(tblBase), .tblLimit(tblLimit), .memAddr(memAddr), .limitFail(limitFail),
    .vecOut(dispVec), .gateType(gateType), .gatePresent(gatePresent),
    .gateSel(gateSel), .gateOff(gateOff),
    .pushAddr(pushAddr), .pushData(pushData), .stackPtr(stackPtr), .entryFlags(entryFlags)
  );

  assign segSel   = gateSel;
  assign taskSel  = gateSel;
  assign entrySel = gateSel;
  assign entryOff = gateOff;

  // R6
  tbl_hold_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(tblBase) && $stable(tblLimit));
endmodule

// File: tb/gateDispatch_tb.sv
module gateDispatch_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN;
  logic        extReq, nmiReq, swReq, excReq;
  logic [7:0]  extVec, swVec, excVec;
  logic [3:0]  srcAck;
  logic        setIe, clrIe, ieFlag;
  logic [1:0]  cpl;
  logic [15:0] flagsIn, csIn, ipIn, spIn;
  logic        tblLoad;
  logic [23:0] tblBaseIn, tblBase;
  logic [15:0] tblLimitIn, tblLimit;
  logic        memRd, memAck;
  logic [23:0] memAddr;
  logic [63:0] memRdata;
  logic        segQuery, segAck, segConf;
  logic [15:0] segSel;
  logic [1:0]  segDpl;
  logic        busy, taskSwitch, procEntry, pushValid, fault;
  logic [7:0]  dispVec;
  logic [15:0] taskSel, entrySel, entryOff, entryFlags, pushAddr, pushData, stackPtr;
  logic [1:0]  faultCode;

  gateDispatch u_dut (
    .clk(clk), .rstN(rstN), .extReq(extReq), .extVec(extVec), .nmiReq(nmiReq),
    .swReq(swReq), .swVec(swVec), .excReq(excReq), .excVec(excVec), .srcAck(srcAck),
    .setIe(setIe), .clrIe(clrIe), .ieFlag(ieFlag), .cpl(cpl),
    .flagsIn(flagsIn), .csIn(csIn), .ipIn(ipIn), .spIn(spIn),
    .tblLoad(tblLoad), .tblBaseIn(tblBaseIn), .tblLimitIn(tblLimitIn),
    .tblBase(tblBase), .tblLimit(tblLimit), .memRd(memRd), .memAddr(memAddr),
    .memAck(memAck), .memRdata(memRdata), .segQuery(segQuery), .segSel(segSel),
    .segAck(segAck), .segDpl(segDpl), .segConf(segConf), .busy(busy), .dispVec(dispVec),
    .taskSwitch(taskSwitch), .taskSel(taskSel), .procEntry(procEntry),
    .entrySel(entrySel), .entryOff(entryOff), .entryFlags(entryFlags),
    .pushValid(pushValid), .pushAddr(pushAddr), .pushData(pushData),
    .stackPtr(stackPtr), .fault(fault), .faultCode(faultCode)
  );

  // memory and segment responders; target segment DPL = sel[14:13], conforming = sel[12]
  logic [63:0] curDesc;
  always @(posedge clk) begin
    memAck   <= memRd && !memAck;
    memRdata <= curDesc;
    segAck   <= segQuery && !segAck;
    segDpl   <= segSel[14:13];
    segConf  <= segSel[12];
  end

  int nChecks = 0;
  int nFail   = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mkDesc(logic [3:0] typ, logic pres, logic [15:0] sel, logic [15:0] off);
    return {16'h0, pres, 2'b00, 1'b0, typ, 8'h00, sel, off};
  endfunction

  // results of one dispatch
  int          gotKind;   // 0 task, 1 entry, 2 fault, 3 none
  logic [15:0] gotSel, gotOff, gotFlags;
  logic [1:0]  gotCode;
  logic [3:0]  gotAck;
  logic [23:0] gotAddr;
  bit          rdSeen, segSeen;
  int          pushCnt;
  logic [15:0] pD [3];
  logic [15:0] pA [3];

  // srcSel bit0 exc, bit1 nmi, bit2 sw, bit3 ext
  task automatic dispatch(input logic [3:0] srcSel, input bit pokeSet);
    bit done;
    @(negedge clk);
    excReq = srcSel[0]; nmiReq = srcSel[1]; swReq = srcSel[2]; extReq = srcSel[3];
    #1 gotAck = srcAck;
    @(negedge clk);
    excReq = 0; nmiReq = 0; swReq = 0; extReq = 0;
    gotKind = 3; pushCnt = 0; rdSeen = 0; segSeen = 0; done = 0; gotAddr = '0;
    for (int i = 0; i < 60 && !done; i++) begin
      if (memRd) begin rdSeen = 1; gotAddr = memAddr; end
      if (segQuery) segSeen = 1;
      if (pushValid && pushCnt < 3) begin
        pD[pushCnt] = pushData; pA[pushCnt] = pushAddr; pushCnt++;
      end
      if (procEntry) begin
        gotKind = 1; gotSel = entrySel; gotOff = entryOff; gotFlags = entryFlags; done = 1;
        if (pokeSet) setIe = 1;
      end
      if (taskSwitch) begin gotKind = 0; gotSel = taskSel; done = 1; end
      if (fault) begin gotKind = 2; gotCode = faultCode; done = 1; end
      if (!done) @(negedge clk);
    end
    @(negedge clk);
    setIe = 0;
  endtask

  typedef struct packed {
    logic [7:0]  vec;
    logic [3:0]  typ;
    logic        pres;
    logic [15:0] sel;
    logic [15:0] off;
    logic [1:0]  cpl;
    logic [1:0]  kind;
    logic [1:0]  code;
  } vecT;

  localparam int NV = 8;
  localparam vecT TV [NV] = '{
    '{8'h20, 4'd5,  1'b1, 16'h0048, 16'h0000, 2'd0, 2'd0, 2'd0},
    '{8'h21, 4'd6,  1'b1, 16'h0008, 16'h1234, 2'd3, 2'd1, 2'd0},
    '{8'h22, 4'd7,  1'b1, 16'h6010, 16'h0400, 2'd3, 2'd1, 2'd0},
    '{8'h23, 4'd6,  1'b1, 16'h6010, 16'h0500, 2'd0, 2'd2, 2'd1},
    '{8'h24, 4'd7,  1'b1, 16'h7018, 16'h0600, 2'd0, 2'd1, 2'd0},
    '{8'h25, 4'd4,  1'b1, 16'h0008, 16'h0700, 2'd0, 2'd2, 2'd1},
    '{8'h26, 4'd6,  1'b0, 16'h0008, 16'h0800, 2'd0, 2'd2, 2'd2},
    '{8'h27, 4'd14, 1'b0, 16'h0008, 16'h0900, 2'd0, 2'd2, 2'd1}
  };

  task automatic loadTbl(input logic [23:0] b, input logic [15:0] l);
    @(negedge clk);
    tblBaseIn = b; tblLimitIn = l; tblLoad = 1;
    @(negedge clk);
    tblLoad = 0;
  endtask

  task automatic pulseIe(input bit s, input bit c);
    @(negedge clk);
    setIe = s; clrIe = c;
    @(negedge clk);
    setIe = 0; clrIe = 0;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [15:0] expF;
    rstN = 0; extReq = 0; nmiReq = 0; swReq = 0; excReq = 0;
    extVec = 0; swVec = 0; excVec = 0; setIe = 0; clrIe = 0; cpl = 0;
    flagsIn = 16'h0302; csIn = 16'h0F00; ipIn = 16'h0ABC; spIn = 16'h0100;
    tblLoad = 0; tblBaseIn = 0; tblLimitIn = 0; curDesc = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 reset ieFlag", ieFlag, 0);
    chk("R6 reset busy", busy, 0);
    chk("R6 reset tblBase", tblBase, 0);

    loadTbl(24'h001000, 16'h07FF);
    chk("R6 base readback", tblBase, 24'h001000);
    chk("R6 limit readback", tblLimit, 16'h07FF);

    // vector table walk through software interrupts
    for (int k = 0; k < NV; k++) begin
      cpl = TV[k].cpl;
      swVec = TV[k].vec;
      curDesc = mkDesc(TV[k].typ, TV[k].pres, TV[k].sel, TV[k].off);
      dispatch(4'b0100, 0);
      chk("R4 table address", gotAddr, 24'h001000 + {13'h0, TV[k].vec, 3'b000});
      chk("R7 R9 R10 outcome kind", gotKind, TV[k].kind);
      if (TV[k].kind == 2) begin
        chk("R7 R8 R10 fault code", gotCode, TV[k].code);
        if (TV[k].code == 2) chk("R8 no segment query", segSeen, 0);
      end else if (TV[k].kind == 0) begin
        chk("R9 task selector", gotSel, TV[k].sel);
        chk("R9 no push", pushCnt, 0);
      end else begin
        chk("R11 entry selector", gotSel, TV[k].sel);
        chk("R11 entry offset", gotOff, TV[k].off);
        chk("R11 push count", pushCnt, 3);
        chk("R11 push flags", {pA[0], pD[0]}, {16'h00FE, 16'h0302});
        chk("R11 push cs", {pA[1], pD[1]}, {16'h00FC, 16'h0F00});
        chk("R11 push ip", {pA[2], pD[2]}, {16'h00FA, 16'h0ABC});
        chk("R11 final stack", stackPtr, 16'h00FA);
        expF = (TV[k].typ == 4'd6) ? 16'h0002 : 16'h0202;
        chk("R12 entry flags", gotFlags, expF);
      end
    end

    // R2: external masked while flag clear; NMI not masked and uses identifier 2
    cpl = 0;
    curDesc = mkDesc(4'd7, 1'b1, 16'h0008, 16'h0100);
    extVec = 8'h40;
    @(negedge clk); extReq = 1;
    #1 chk("R2 ext not acked when masked", srcAck, 4'b0000);
    @(negedge clk); extReq = 0;
    repeat (4) @(negedge clk);
    chk("R2 masked ext leaves block idle", busy, 0);
    dispatch(4'b0010, 0);
    chk("R3 nmi ack", gotAck, 4'b0010);
    chk("R3 nmi identifier 2", gotAddr, 24'h001010);
    chk("R2 nmi served with flag clear", gotKind, 1);

    // R1 flag commands
    pulseIe(1, 0);
    chk("R1 setIe", ieFlag, 1);
    pulseIe(1, 1);
    chk("R1 clr wins over set", ieFlag, 0);
    pulseIe(1, 0);
    chk("R1 set again", ieFlag, 1);

    // R3 priority
    excVec = 8'h0D; swVec = 8'h30;
    dispatch(4'b1011, 0);
    chk("R3 exception first", gotAck, 4'b0001);
    chk("R3 exception address", gotAddr, 24'h001068);
    dispatch(4'b1010, 0);
    chk("R3 nmi over ext", gotAck, 4'b0010);
    dispatch(4'b1100, 0);
    chk("R3 sw over ext", gotAck, 4'b0100);
    dispatch(4'b1000, 0);
    chk("R2 ext accepted when enabled", gotAck, 4'b1000);
    chk("R4 ext address", gotAddr, 24'h001200);
    chk("R12 trap keeps ieFlag", ieFlag, 1);

    // R12 interrupt gate clears flag
    curDesc = mkDesc(4'd6, 1'b1, 16'h0008, 16'h0100);
    dispatch(4'b0100, 0);
    chk("R12 interrupt gate clears ieFlag", ieFlag, 0);
    // R13 setIe in the entry cycle loses
    pulseIe(1, 0);
    dispatch(4'b0100, 1);
    chk("R13 entry clear beats setIe", gotKind * 2 + ieFlag, 2);

    // R5 limit
    loadTbl(24'h001000, 16'h00FF);
    curDesc = mkDesc(4'd7, 1'b1, 16'h0008, 16'h0100);
    swVec = 8'h1F;
    dispatch(4'b0100, 0);
    chk("R5 last entry inside limit", gotKind, 1);
    swVec = 8'h20;
    dispatch(4'b0100, 0);
    chk("R5 beyond limit faults", {gotKind[1:0], gotCode}, {2'd2, 2'd1});
    chk("R5 no read issued", rdSeen, 0);

    // R6 load while busy ignored, then switch tables
    swVec = 8'h05;
    @(negedge clk); swReq = 1;
    @(negedge clk); swReq = 0; tblLoad = 1; tblBaseIn = 24'h005000; tblLimitIn = 16'h0010;
    @(negedge clk); tblLoad = 0;
    repeat (20) @(negedge clk);
    chk("R6 busy load ignored base", tblBase, 24'h001000);
    chk("R6 busy load ignored limit", tblLimit, 16'h00FF);
    loadTbl(24'h002000, 16'h07FF);
    dispatch(4'b0100, 0);
    chk("R6 new table used", gotAddr, 24'h002028);

    finishRun();
  end
endmodule